// File: doc/BRIEF.md
# Two-Mode Multicart Bank Mapper

This block sits between the CPU bus of a handheld console and the ROM and battery-less RAM of a multi-game cartridge. After reset it passes CPU addresses below 0x8000 straight to the ROM, so a menu program at the start of the image can run. While it is in this mode the menu picks a base bank for the chosen game. The first write to the lowest control window then latches the mapper into banked mode. Only reset clears that latch.

In banked mode every ROM access is moved up by two banks plus the base. The fixed window 0x0000-0x3FFF shows the game's first bank. The switchable window 0x4000-0x7FFF shows a further offset bank, and that offset is clamped so that it cannot leave the image. Banked mode also gives the game a RAM enable gate and a RAM bank select for the external RAM window 0xA000-0xBFFF. The ROM and RAM bank counts of the fitted cartridge come in on ports. The physical addresses, the RAM write strobe and the read-data select are all registered.

Top module: `mcm_mapper`

## Requirements
- R1: Reset (synchronous, active high) leaves pass-through mode, base bank 0, offset bank 1, RAM bank 0, RAM disabled, `ram_we` low and `cpu_rdata` at 0xFF.
- R2: In pass-through mode a read of 0x0000-0x7FFF drives `rom_addr` with the CPU address unchanged and returns `rom_rdata`.
- R3: In pass-through mode a write to 0x0000-0x1FFF switches to banked mode. Further writes there never return the mapper to pass-through mode. Only reset does.
- R4: In banked mode a write to 0x0000-0x1FFF enables RAM when bits 3:0 of the data equal 0xA and disables it for any other value. In pass-through mode the same write leaves RAM disabled.
- R5: In pass-through mode a write to 0x2000-0x3FFF sets the base to (data & 0x3F) mod (`rom_banks` - 2). When `rom_banks` is 2 or less, the base becomes 0.
- R6: In banked mode a write to 0x2000-0x3FFF sets the offset to the data value, leaving the base alone. If base + data exceeds `rom_banks` - 3, the offset becomes `rom_banks` - 3 - base. When `rom_banks` is below 3, the offset becomes 0.
- R7: In banked mode a read of 0x0000-0x3FFF maps to (2 + base) * 0x4000 + address. A read of 0x4000-0x7FFF maps to (2 + base + offset) * 0x4000 + (address - 0x4000). Both are truncated to the `rom_addr` width.
- R8: In banked mode a write to 0x4000-0x5FFF sets the RAM bank to data mod `ram_banks`, or to 0 when `ram_banks` is 0. In pass-through mode such writes are ignored.
- R9: While RAM is enabled and `ram_banks` is non-zero, an access to 0xA000-0xBFFF drives `ram_addr` = bank * 0x2000 + (address - 0xA000). A write raises `ram_we` with the data on `ram_wdata`. A read returns `ram_rdata`.
- R10: While RAM is disabled or `ram_banks` is 0, writes to 0xA000-0xBFFF are dropped (no `ram_we`) and reads of that window return 0xFF.
- R11: A read of any other address, and any cycle without a read, gives `cpu_rdata` = 0xFF.
- R12: Every output reflects the request presented before a rising clock edge from just after that edge, and does not change before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_rd | input | 1 | CPU read strobe |
| rom_banks | input | ROM_BANK_W+1 | Number of 16 KiB ROM banks in the image |
| ram_banks | input | RAM_BANK_W+1 | Number of 8 KiB RAM banks fitted |
| rom_rdata | input | 8 | Data from ROM at `rom_addr` |
| ram_rdata | input | 8 | Data from RAM at `ram_addr` |
| rom_addr | output | ROM_BANK_W+14 | Physical ROM byte address |
| ram_addr | output | RAM_BANK_W+13 | Physical RAM byte address |
| ram_wdata | output | 8 | RAM write data |
| ram_we | output | 1 | RAM write enable |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
Every address output, the write strobe and the read-data select are due exactly one rising edge after the request. The bench therefore drives each request just after a falling edge and compares all outputs at the next falling edge, half a period after the edge that registers them. A control write changes the mapping seen by the access in the following cycle. A RAM write lands in memory on the edge after `ram_we` shows, so a read issued straight afterwards already returns the new byte. One extra check samples `rom_addr` before the edge to confirm it still holds the previous request.

// File: rtl/mcm_pkg.sv
package mcm_pkg;
  typedef enum logic [1:0] {SRC_FILL, SRC_ROM, SRC_RAM} rd_src_t;
  localparam logic [2:0] WIN_CTRL0 = 3'd0;
  localparam logic [2:0] WIN_BANK  = 3'd1;
  localparam logic [2:0] WIN_RAMSEL = 3'd2;
  localparam logic [2:0] WIN_XRAM  = 3'd5;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/mcm_ctrl.sv
module mcm_ctrl #(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [2:0]            region,
  input  logic [7:0]            wdata,
  input  logic [ROM_BANK_W:0]   rom_cnt,
  input  logic [RAM_BANK_W:0]   ram_cnt,
  output logic                  banked,
  output logic [5:0]            base,
  output logic [7:0]            offset,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_en
);
  import mcm_pkg::*;

  localparam int CW = (ROM_BANK_W + 2 > 9) ? ROM_BANK_W + 2 : 9;
  localparam int RW = (RAM_BANK_W + 1 > 8) ? RAM_BANK_W + 1 : 8;

  logic [CW-1:0]         cnt_w, lim, base_w, data_w;
  logic [5:0]            base_mod;
  logic [7:0]            off_clamp;
  logic [RAM_BANK_W-1:0] rb_mod;

  always_comb begin
    cnt_w  = CW'(rom_cnt);
    lim    = cnt_w - CW'(3);
    base_w = CW'(base);
    data_w = CW'(wdata);
    base_mod = '0;
    if (cnt_w > CW'(2))
      base_mod = 6'(CW'(wdata[5:0]) % (cnt_w - CW'(2)));
    if (cnt_w < CW'(3) || base_w > lim)
      off_clamp = '0;
    else if (base_w + data_w > lim)
      off_clamp = 8'(lim - base_w);
    else
      off_clamp = wdata;
    rb_mod = '0;
    if (ram_cnt != '0)
      rb_mod = RAM_BANK_W'(RW'(wdata) % RW'(ram_cnt));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      banked   <= 1'b0;
      base     <= '0;
      offset   <= 8'd1;
      ram_bank <= '0;
      ram_en   <= 1'b0;
    end else if (wr) begin
      case (region)
        WIN_CTRL0: begin
          if (!banked) banked <= 1'b1;
          else         ram_en <= (wdata[3:0] == 4'hA);
        end
        WIN_BANK: begin
          if (!banked) base   <= base_mod;
          else         offset <= off_clamp;
        end
        WIN_RAMSEL: begin
          if (banked) ram_bank <= rb_mod;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mcm_rom_map.sv
module mcm_rom_map #(
  parameter int ROM_BANK_W = 7
) (
  input  logic                   banked,
  input  logic [5:0]             base,
  input  logic [7:0]             offset,
  input  logic [14:0]            addr,
  output logic [ROM_BANK_W+13:0] rom_addr
);
  localparam int ROM_AW = ROM_BANK_W + 14;

  logic [ROM_BANK_W-1:0] bank_idx;

  always_comb begin
    bank_idx = ROM_BANK_W'(2) + ROM_BANK_W'(base)
             + (addr[14] ? ROM_BANK_W'(offset) : '0);
    if (banked)
      rom_addr = {bank_idx, addr[13:0]};
    else
      rom_addr = ROM_AW'(addr);
  end
endmodule

// File: rtl/mcm_ram_gate.sv
module mcm_ram_gate #(
  parameter int RAM_BANK_W = 4
) (
  input  logic                   rd,
  input  logic                   wr,
  input  logic [15:0]            addr,
  input  logic                   ram_en,
  input  logic [RAM_BANK_W:0]    ram_cnt,
  input  logic [RAM_BANK_W-1:0]  ram_bank,
  output logic [RAM_BANK_W+12:0] ram_addr,
  output logic                   we,
  output mcm_pkg::rd_src_t       src
);
  import mcm_pkg::*;

  logic in_win, open;

  always_comb begin
    in_win   = (addr[15:13] == WIN_XRAM);
    open     = ram_en && (ram_cnt != '0);
    ram_addr = {ram_bank, addr[12:0]};
    we       = wr && in_win && open;
    if (rd && !addr[15])
      src = SRC_ROM;
    else if (rd && in_win && open)
      src = SRC_RAM;
    else
      src = SRC_FILL;
  end
endmodule

// File: rtl/mcm_mapper.sv
module mcm_mapper #(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [15:0]            cpu_addr,
  input  logic [7:0]             cpu_wdata,
  input  logic                   cpu_wr,
  input  logic                   cpu_rd,
  input  logic [ROM_BANK_W:0]    rom_banks,
  input  logic [RAM_BANK_W:0]    ram_banks,
  input  logic [7:0]             rom_rdata,
  input  logic [7:0]             ram_rdata,
  output logic [ROM_BANK_W+13:0] rom_addr,
  output logic [RAM_BANK_W+12:0] ram_addr,
  output logic [7:0]             ram_wdata,
  output logic                   ram_we,
  output logic [7:0]             cpu_rdata
);
  import mcm_pkg::*;

  localparam int ROM_AW = ROM_BANK_W + 14;
  localparam int RAM_AW = RAM_BANK_W + 13;

  logic                  banked, ram_en;
  logic [5:0]            base_bank;
  logic [7:0]            off_bank;
  logic [RAM_BANK_W-1:0] ram_bank;
  logic [ROM_AW-1:0]     rom_addr_d;
  logic [RAM_AW-1:0]     ram_addr_d;
  logic                  we_d;
  rd_src_t               src_d, src_q;

  mcm_ctrl #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_ctrl (
    .clk(clk), .rst(rst), .wr(cpu_wr), .region(cpu_addr[15:13]),
    .wdata(cpu_wdata), .rom_cnt(rom_banks), .ram_cnt(ram_banks),
    .banked(banked), .base(base_bank), .offset(off_bank),
    .ram_bank(ram_bank), .ram_en(ram_en)
  );

  mcm_rom_map #(.ROM_BANK_W(ROM_BANK_W)) u_rom_map (
    .banked(banked), .base(base_bank), .offset(off_bank),
    .addr(cpu_addr[14:0]), .rom_addr(rom_addr_d)
  );

  mcm_ram_gate #(.RAM_BANK_W(RAM_BANK_W)) u_ram_gate (
    .rd(cpu_rd), .wr(cpu_wr), .addr(cpu_addr), .ram_en(ram_en),
    .ram_cnt(ram_banks), .ram_bank(ram_bank),
    .ram_addr(ram_addr_d), .we(we_d), .src(src_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_addr  <= '0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      ram_we    <= 1'b0;
      src_q     <= SRC_FILL;
    end else begin
      rom_addr  <= rom_addr_d;
      ram_addr  <= ram_addr_d;
      ram_wdata <= cpu_wdata;
      ram_we    <= we_d;
      src_q     <= src_d;
    end
  end

  always_comb begin
    case (src_q)
      SRC_ROM: cpu_rdata = rom_rdata;
      SRC_RAM: cpu_rdata = ram_rdata;
      default: cpu_rdata = FILL_BYTE;
    endcase
  end
endmodule

// File: rtl/mcm_check.sv
module mcm_check #(
  parameter int ROM_BANK_W = 7
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          region,
  input logic                cpu_wr,
  input logic                cpu_rd,
  input logic [ROM_BANK_W:0] rom_banks,
  input logic                banked,
  input logic [5:0]          base,
  input logic [7:0]          offset,
  input logic                ram_en,
  input logic                ram_we,
  input logic [7:0]          cpu_rdata
);
  // R1: state right after reset
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!banked && !ram_en && base == 6'd0 && offset == 8'd1 && !ram_we));

  // R3: banked mode is one-way
  a_r3_mode_sticky: assert property (@(posedge clk) disable iff (rst)
    banked |=> banked);

  // R5: base stays below the modulus
  a_r5_base_range: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && region == 3'd1 && !banked && int'(rom_banks) > 2)
    |=> (int'(base) < int'($past(rom_banks)) - 2));

  // R6: offset clamp keeps the window inside the image
  a_r6_offset_clamp: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && region == 3'd1 && banked && int'(rom_banks) >= 3)
    |=> (int'(base) + int'(offset) <= int'($past(rom_banks)) - 3));

  // R10: a RAM write only follows an enabled write to the RAM window
  a_r10_we_gated: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ($past(ram_en) && $past(cpu_wr) && $past(region) == 3'd5));

  // R11: no read means filler data
  a_r11_idle_fill: assert property (@(posedge clk) disable iff (rst)
    !$past(cpu_rd) |-> (cpu_rdata == 8'hFF));
endmodule

bind mcm_mapper mcm_check #(.ROM_BANK_W(ROM_BANK_W)) u_check (
  .clk(clk), .rst(rst), .region(cpu_addr[15:13]), .cpu_wr(cpu_wr),
  .cpu_rd(cpu_rd), .rom_banks(rom_banks), .banked(banked),
  .base(base_bank), .offset(off_bank), .ram_en(ram_en),
  .ram_we(ram_we), .cpu_rdata(cpu_rdata)
);

// File: tb/mcm_mapper_test.sv
`timescale 1ns/1ps
module mcm_mapper_test;
  localparam int RBW = 7;
  localparam int MBW = 4;
  localparam int RAW = RBW + 14;
  localparam int MAW = MBW + 13;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [15:0]    cpu_addr = '0;
  logic [7:0]     cpu_wdata = '0;
  logic           cpu_wr = 1'b0;
  logic           cpu_rd = 1'b0;
  logic [RBW:0]   rom_banks = 8'd40;
  logic [MBW:0]   ram_banks = 5'd4;
  logic [7:0]     rom_rdata, ram_rdata, ram_wdata, cpu_rdata;
  logic [RAW-1:0] rom_addr;
  logic [MAW-1:0] ram_addr;
  logic           ram_we;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int m_banked, m_base, m_off, m_rb, m_ren;
  int ram_ref [int];
  logic [7:0] bram [0:1023];

  always #2.5 clk = ~clk;

  mcm_mapper #(.ROM_BANK_W(RBW), .RAM_BANK_W(MBW)) uut (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_banks(rom_banks),
    .ram_banks(ram_banks), .rom_rdata(rom_rdata), .ram_rdata(ram_rdata),
    .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .cpu_rdata(cpu_rdata)
  );

  function automatic logic [7:0] rom_byte(int a);
    int t;
    t = a ^ (a >> 8) ^ (a >> 16);
    return 8'(t + 91);
  endfunction

  assign rom_rdata = rom_byte(int'(rom_addr));
  assign ram_rdata = bram[{ram_addr[14:13], ram_addr[7:0]}];

  initial for (int i = 0; i < 1024; i++) bram[i] = 8'h00;
  always @(posedge clk) if (ram_we) bram[{ram_addr[14:13], ram_addr[7:0]}] <= ram_wdata;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_banked = 0; m_base = 0; m_off = 1; m_rb = 0; m_ren = 0;
  endtask

  task automatic op(bit rd, bit wr, int addr, int data, string req);
    int cnt, rcnt, ea, key, lim;
    bit ok, inram;
    cpu_rd = rd; cpu_wr = wr; cpu_addr = 16'(addr); cpu_wdata = 8'(data);
    cnt = int'(rom_banks);
    rcnt = int'(ram_banks);
    ok = (m_ren != 0) && (rcnt != 0);
    inram = ((addr >> 13) == 5);
    @(negedge clk);
    check({req, " ram_we"}, int'(ram_we), (wr && inram && ok) ? 1 : 0);
    if (wr && inram && ok) begin
      key = m_rb * 8192 + (addr & 8191);
      check({req, " ram_addr"}, int'(ram_addr), key);
      check({req, " ram_wdata"}, int'(ram_wdata), data & 255);
      ram_ref[key] = data & 255;
    end
    if (rd && addr < 32768) begin
      if (m_banked != 0)
        ea = ((2 + m_base + ((addr >= 16384) ? m_off : 0)) * 16384 + (addr & 16383)) & ((1 << RAW) - 1);
      else
        ea = addr;
      check({req, " rom_addr"}, int'(rom_addr), ea);
      check({req, " rdata"}, int'(cpu_rdata), int'(rom_byte(ea)));
    end else if (rd && inram && ok) begin
      key = m_rb * 8192 + (addr & 8191);
      check({req, " ram_addr"}, int'(ram_addr), key);
      check({req, " rdata"}, int'(cpu_rdata), ram_ref.exists(key) ? ram_ref[key] : 0);
    end else begin
      check({req, " rdata fill"}, int'(cpu_rdata), 255);
    end
    if (wr) begin
      case (addr >> 13)
        0: if (m_banked == 0) m_banked = 1; else m_ren = ((data & 15) == 10) ? 1 : 0;
        1: begin
          if (m_banked == 0) begin
            m_base = (cnt > 2) ? (data & 63) % (cnt - 2) : 0;
          end else begin
            lim = cnt - 3;
            if (cnt < 3 || m_base > lim) m_off = 0;
            else if (m_base + data > lim) m_off = lim - m_base;
            else m_off = data;
          end
        end
        2: if (m_banked != 0) m_rb = (rcnt == 0) ? 0 : data % rcnt;
        default: ;
      endcase
    end
    cpu_rd = 0; cpu_wr = 0;
  endtask

  task automatic do_reset();
    rst = 1; cpu_rd = 0; cpu_wr = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    op(0, 0, 'h0000, 0, "R1 idle after reset");
    op(1, 0, 'h4123, 0, "R1 R2 pass read uses offset-free address");
    op(1, 0, 'h0000, 0, "R2 pass read bank0");
    cpu_rd = 1; cpu_addr = 16'h0777;
    #1;
    check("R12 rom_addr holds before edge", int'(rom_addr), 'h0000);
    op(1, 0, 'h0777, 0, "R12 R2 pass read after edge");
    op(1, 0, 'h8000, 0, "R11 video window read");
    op(1, 0, 'hFF80, 0, "R11 high read");
    op(1, 0, 'hA010, 0, "R10 RAM read while disabled");
    op(0, 1, 'h4000, 3, "R8 ram select ignored in pass mode");
    op(0, 1, 'h2000, 'h7F, "R5 base 63 mod 38");
    op(0, 1, 'h2000, 'h05, "R5 base 5");
    op(0, 1, 'h1000, 'h0A, "R3 R4 switch to banked, RAM stays off");
    op(0, 1, 'hA005, 'h33, "R4 R10 write dropped after switch");
    op(1, 0, 'h0100, 0, "R7 fixed window");
    op(1, 0, 'h4010, 0, "R7 switch window offset 1");
    op(0, 1, 'h2000, 'h30, "R6 clamp offset");
    op(1, 0, 'h7FFF, 0, "R6 R7 last bank of image");
    op(1, 0, 'h0200, 0, "R6 base unchanged by banked write");
    op(0, 1, 'h0000, 'h00, "R3 no return to pass mode");
    op(1, 0, 'h2000, 0, "R3 still banked");
    op(0, 1, 'h0000, 'h3A, "R4 enable by low nibble");
    op(0, 1, 'h4000, 6, "R8 ram bank 6 mod 4");
    op(1, 0, 'hA005, 0, "R8 R9 read unwritten location");
    op(0, 1, 'hA005, 'h77, "R9 RAM write");
    op(1, 0, 'hA005, 0, "R9 RAM readback");
    op(0, 1, 'h0000, 'h1B, "R4 disable by other nibble");
    op(0, 1, 'hA005, 'h55, "R10 write while disabled");
    op(1, 0, 'hA005, 0, "R10 read while disabled");
    op(0, 1, 'h0000, 'h0A, "R4 re-enable");
    op(1, 0, 'hA005, 0, "R10 dropped write left data");
    ram_banks = 5'd0;
    op(1, 0, 'hA005, 0, "R10 zero RAM banks read");
    op(0, 1, 'hA006, 'h12, "R10 zero RAM banks write");
    op(0, 1, 'h4000, 9, "R8 zero RAM banks select");
    ram_banks = 5'd4;
    op(1, 0, 'hA005, 0, "R8 R9 bank 0 after zero-count select");
    op(0, 1, 'h2000, 0, "R6 offset zero");
    op(1, 0, 'h4000, 0, "R7 offset zero maps to base bank");
    op(1, 0, 'hC000, 0, "R11 work RAM window");
    do_reset();
    op(1, 0, 'h4123, 0, "R1 R3 reset returns to pass mode");
    rom_banks = 8'd2;
    op(0, 1, 'h2000, 'h15, "R5 small image base 0");
    op(0, 1, 'h1FFF, 0, "R3 switch small image");
    op(1, 0, 'h0000, 0, "R7 small image fixed window");
    op(0, 1, 'h2000, 9, "R6 small image offset 0");
    op(1, 0, 'h4001, 0, "R6 R7 small image switch window");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule